// File: doc/BRIEF.md
# Timer-channel monitor command and interrupt sequencer

This block is the control unit that sits between a host and a bank of per-task timer channels in an execution-time monitor. Each channel owns a down-counter, maximum and minimum limit registers and a small control register holding an enable bit and two clock-pace bits. The channels report an expired maximum time through a request line and a too-early condition through an early flag. This block turns host commands and channel requests into single-cycle strobes aimed at one channel at a time.

A pending expiry always wins over a new command. On an expiry the sequencer selects the lowest-numbered expired channel. It records that channel's number in the status word, resets and disables the channel, and then holds until the host acknowledges. A command word carries a channel number, a 4-bit operation code and two pace bits. It is accepted only while idle. It takes one decode cycle, which writes the pace bits, and one action cycle, which drives the strobes for the operation. Any data that is read back is captured into a read-data register.

Top module: `mon_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, status_o and rd_data_o are 0 and every per-channel strobe vector and ack_o are 0 until a command or request arrives.
- R2: intr_o is high in exactly those cycles in which at least one bit of tc_req_i is high.
- R3: A request pending in the idle state is served before a command offered in the same cycle. That command is dropped, and no pace strobe follows it.
- R4: Interrupt service takes one cycle. It drives rst_cnt_o and ld_en_o (with en_o=0) one-hot at the lowest-numbered set bit of tc_req_i, where channel 0 has the highest priority. From the next cycle, status_o holds that channel number in bits 4:0 with bit 5 cleared.
- R5: After service the sequencer accepts no command until inta_i is seen high. In that cycle ack_o is one-hot at the served channel. The next cycle is idle.
- R6: The command word holds the channel number in bits 4:0, the code in bits 8:5 and the pace bits in bits 10:9. The cycle after acceptance drives ld_pace_o one-hot at the channel, with pace_o equal to the pace bits.
- R7: Code 0000 (start) drives ld_cnt_max_o and ld_en_o with en_o=1. Code 0001 (pause) drives ld_en_o with en_o=0. Code 0100 (resume) drives ld_en_o with en_o=1.
- R8: Code 0010 (finish) drives ld_en_o with en_o=0 and copies early_i of the addressed channel into status_o bit 5. Bits 4:0 are left unchanged.
- R9: Code 0011 (measure start) drives rst_cnt_o and ld_en_o with en_o=1. Code 0101 (measure stop) drives ld_en_o with en_o=0 and oe_cnt_o, and captures rd_bus_i into rd_data_o.
- R10: Codes 0110, 0111 and 1000 drive ld_cnt_o, ld_max_o and ld_min_o respectively.
- R11: Codes 1001, 1010 and 1011 drive oe_cnt_o, oe_max_o and oe_min_o respectively, and rd_data_o takes the value on rd_bus_i in that cycle. rd_data_o changes at no other time.
- R12: Codes 1100 to 1111 produce no strobe and no pace write and leave status_o and rd_data_o unchanged. The sequencer is idle again in the cycle after the decode cycle.
- R13: A command's action strobes occur exactly two cycles after acceptance. Each lasts one cycle, and every strobe vector is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word offered this cycle |
| cmd_word_i | input | 11 | Pace[10:9], code[8:5], channel[4:0] |
| tc_req_i | input | 32 | Per-channel maximum-time expiry requests |
| early_i | input | 32 | Per-channel finished-too-early flags |
| inta_i | input | 1 | Host interrupt acknowledge |
| rd_bus_i | input | 16 | Value a channel puts out under an output enable |
| intr_o | output | 1 | Interrupt request to host |
| status_o | output | 16 | Channel number [4:0], early flag [5] |
| rd_data_o | output | 16 | Read-data register |
| pace_o | output | 2 | Pace bits written with ld_pace_o |
| en_o | output | 1 | Enable value written with ld_en_o |
| ld_pace_o | output | 32 | Write pace bits of channel |
| ld_en_o | output | 32 | Write enable bit of channel |
| ld_cnt_o | output | 32 | Load counter from write data |
| ld_cnt_max_o | output | 32 | Load counter from maximum limit |
| ld_max_o | output | 32 | Load maximum limit from write data |
| ld_min_o | output | 32 | Load minimum limit from write data |
| rst_cnt_o | output | 32 | Reset counter |
| oe_cnt_o | output | 32 | Put counter on read bus |
| oe_max_o | output | 32 | Put maximum limit on read bus |
| oe_min_o | output | 32 | Put minimum limit on read bus |
| ack_o | output | 32 | Clear expiry request of channel |

## Verification
On every cycle the assertions check that strobes stay one-hot, that service picks the lowest pending channel, and that acknowledge pulses need inta_i. They also check that every action strobe is preceded by a pace strobe to the same channel, and that rd_data_o moves only after an output enable. Which strobes belong to each operation code, the captured values, the early-flag transfer, and the dropping of a command that collides with a request can only be shown by the bench's scenarios. The same holds for the wait for acknowledge and the immediate return to idle after a reserved code.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [2:0] {
    ST_RESET, ST_IDLE, ST_DECODE, ST_EXEC, ST_IRQ, ST_IRQ_WAIT
  } state_e;

  typedef enum logic [3:0] {
    OP_START     = 4'h0,
    OP_PAUSE     = 4'h1,
    OP_FINISH    = 4'h2,
    OP_MEAS_GO   = 4'h3,
    OP_RESUME    = 4'h4,
    OP_MEAS_STOP = 4'h5,
    OP_LD_CNT    = 4'h6,
    OP_LD_MAX    = 4'h7,
    OP_LD_MIN    = 4'h8,
    OP_RD_CNT    = 4'h9,
    OP_RD_MAX    = 4'hA,
    OP_RD_MIN    = 4'hB
  } op_e;

  localparam logic [3:0] OP_LAST = 4'hB;

  typedef struct packed {
    logic ld_pace;
    logic ld_en;
    logic ld_cnt;
    logic ld_cnt_max;
    logic ld_max;
    logic ld_min;
    logic rst_cnt;
    logic oe_cnt;
    logic oe_max;
    logic oe_min;
    logic ack;
  } strobe_t;

  localparam int STROBE_N = $bits(strobe_t);
endpackage

// File: rtl/mon_prio_enc.sv
module mon_prio_enc #(
  parameter int NUM_CH = 32,
  localparam int ID_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic [ID_W-1:0]   id_o
);
  // lowest index wins
  always_comb begin
    id_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/mon_onehot_dec.sv
module mon_onehot_dec #(
  parameter int NUM_CH = 32,
  localparam int ID_W = $clog2(NUM_CH)
) (
  input  logic              en_i,
  input  logic [ID_W-1:0]   id_i,
  output logic [NUM_CH-1:0] vec_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign vec_o[c] = en_i && (id_i == ID_W'(c));
  end
endmodule

// File: rtl/mon_fsm.sv
module mon_fsm
  import mon_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 16,
  localparam int ID_W  = $clog2(NUM_CH),
  localparam int CMD_W = ID_W + 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic              intr_i,
  input  logic [ID_W-1:0]   irq_id_i,
  input  logic [NUM_CH-1:0] early_i,
  input  logic              inta_i,
  input  logic [DATA_W-1:0] rd_bus_i,
  output strobe_t           stb_o,
  output logic              en_o,
  output logic [1:0]        pace_o,
  output logic [ID_W-1:0]   tgt_id_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] rd_data_o
);
  state_e            state_q, state_d;
  logic [CMD_W-1:0]  cmd_q;
  logic [ID_W-1:0]   irq_q;
  logic [ID_W-1:0]   cmd_id;
  logic [3:0]        cmd_op;
  logic              capture;

  assign cmd_id = cmd_q[ID_W-1:0];
  assign cmd_op = cmd_q[ID_W+3:ID_W];
  assign pace_o = cmd_q[ID_W+5:ID_W+4];

  always_comb begin
    state_d  = state_q;
    stb_o    = '0;
    en_o     = 1'b0;
    tgt_id_o = cmd_id;
    capture  = 1'b0;
    unique case (state_q)
      ST_RESET: state_d = ST_IDLE;
      ST_IDLE: begin
        if (intr_i)           state_d = ST_IRQ;
        else if (cmd_valid_i) state_d = ST_DECODE;
      end
      ST_DECODE: begin
        if (cmd_op <= OP_LAST) begin
          stb_o.ld_pace = 1'b1;
          state_d       = ST_EXEC;
        end else begin
          state_d       = ST_IDLE;
        end
      end
      ST_EXEC: begin
        state_d = ST_IDLE;
        case (cmd_op)
          OP_START:     begin stb_o.ld_cnt_max = 1'b1; stb_o.ld_en = 1'b1; en_o = 1'b1; end
          OP_PAUSE:     stb_o.ld_en = 1'b1;
          OP_FINISH:    stb_o.ld_en = 1'b1;
          OP_MEAS_GO:   begin stb_o.rst_cnt = 1'b1; stb_o.ld_en = 1'b1; en_o = 1'b1; end
          OP_RESUME:    begin stb_o.ld_en = 1'b1; en_o = 1'b1; end
          OP_MEAS_STOP: begin stb_o.ld_en = 1'b1; stb_o.oe_cnt = 1'b1; capture = 1'b1; end
          OP_LD_CNT:    stb_o.ld_cnt = 1'b1;
          OP_LD_MAX:    stb_o.ld_max = 1'b1;
          OP_LD_MIN:    stb_o.ld_min = 1'b1;
          OP_RD_CNT:    begin stb_o.oe_cnt = 1'b1; capture = 1'b1; end
          OP_RD_MAX:    begin stb_o.oe_max = 1'b1; capture = 1'b1; end
          OP_RD_MIN:    begin stb_o.oe_min = 1'b1; capture = 1'b1; end
          default: ;
        endcase
      end
      ST_IRQ: begin
        tgt_id_o      = irq_id_i;
        stb_o.rst_cnt = 1'b1;
        stb_o.ld_en   = 1'b1;
        state_d       = ST_IRQ_WAIT;
      end
      ST_IRQ_WAIT: begin
        tgt_id_o = irq_q;
        if (inta_i) begin
          stb_o.ack = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RESET;
      cmd_q     <= '0;
      irq_q     <= '0;
      status_o  <= '0;
      rd_data_o <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && !intr_i && cmd_valid_i) cmd_q <= cmd_word_i;
      if (state_q == ST_IRQ) begin
        irq_q    <= irq_id_i;
        status_o <= DATA_W'(irq_id_i);
      end
      if (state_q == ST_EXEC && cmd_op == OP_FINISH) status_o[ID_W] <= early_i[cmd_id];
      if (capture) rd_data_o <= rd_bus_i;
    end
  end
endmodule

// File: rtl/mon_ctrl.sv
module mon_ctrl
  import mon_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  input  logic [$clog2(NUM_CH)+5:0]   cmd_word_i,
  input  logic [NUM_CH-1:0]           tc_req_i,
  input  logic [NUM_CH-1:0]           early_i,
  input  logic                        inta_i,
  input  logic [DATA_W-1:0]           rd_bus_i,
  output logic                        intr_o,
  output logic [DATA_W-1:0]           status_o,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [1:0]                  pace_o,
  output logic                        en_o,
  output logic [NUM_CH-1:0]           ld_pace_o,
  output logic [NUM_CH-1:0]           ld_en_o,
  output logic [NUM_CH-1:0]           ld_cnt_o,
  output logic [NUM_CH-1:0]           ld_cnt_max_o,
  output logic [NUM_CH-1:0]           ld_max_o,
  output logic [NUM_CH-1:0]           ld_min_o,
  output logic [NUM_CH-1:0]           rst_cnt_o,
  output logic [NUM_CH-1:0]           oe_cnt_o,
  output logic [NUM_CH-1:0]           oe_max_o,
  output logic [NUM_CH-1:0]           oe_min_o,
  output logic [NUM_CH-1:0]           ack_o
);
  localparam int ID_W = $clog2(NUM_CH);

  strobe_t                stb;
  logic [STROBE_N-1:0]    stb_bits;
  logic [ID_W-1:0]        irq_id;
  logic [ID_W-1:0]        tgt_id;
  logic [NUM_CH-1:0]      vec [STROBE_N];

  assign intr_o   = |tc_req_i;
  assign stb_bits = stb;

  mon_prio_enc #(.NUM_CH(NUM_CH)) u_prio (
    .req_i (tc_req_i),
    .id_o  (irq_id)
  );

  mon_fsm #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_word_i  (cmd_word_i),
    .intr_i      (intr_o),
    .irq_id_i    (irq_id),
    .early_i     (early_i),
    .inta_i      (inta_i),
    .rd_bus_i    (rd_bus_i),
    .stb_o       (stb),
    .en_o        (en_o),
    .pace_o      (pace_o),
    .tgt_id_o    (tgt_id),
    .status_o    (status_o),
    .rd_data_o   (rd_data_o)
  );

  for (genvar k = 0; k < STROBE_N; k++) begin : g_dec
    mon_onehot_dec #(.NUM_CH(NUM_CH)) u_dec (
      .en_i  (stb_bits[k]),
      .id_i  (tgt_id),
      .vec_o (vec[k])
    );
  end

  assign ld_pace_o    = vec[10];
  assign ld_en_o      = vec[9];
  assign ld_cnt_o     = vec[8];
  assign ld_cnt_max_o = vec[7];
  assign ld_max_o     = vec[6];
  assign ld_min_o     = vec[5];
  assign rst_cnt_o    = vec[4];
  assign oe_cnt_o     = vec[3];
  assign oe_max_o     = vec[2];
  assign oe_min_o     = vec[1];
  assign ack_o        = vec[0];
endmodule

// File: rtl/mon_ctrl_chk.sv
module mon_ctrl_chk #(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] tc_req_i,
  input logic              inta_i,
  input logic              en_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NUM_CH-1:0] ld_pace_o,
  input logic [NUM_CH-1:0] ld_en_o,
  input logic [NUM_CH-1:0] ld_cnt_o,
  input logic [NUM_CH-1:0] ld_cnt_max_o,
  input logic [NUM_CH-1:0] ld_max_o,
  input logic [NUM_CH-1:0] ld_min_o,
  input logic [NUM_CH-1:0] rst_cnt_o,
  input logic [NUM_CH-1:0] oe_cnt_o,
  input logic [NUM_CH-1:0] oe_max_o,
  input logic [NUM_CH-1:0] oe_min_o,
  input logic [NUM_CH-1:0] ack_o
);
  logic [NUM_CH-1:0] act_vec;
  logic              irq_cycle;
  assign act_vec   = ld_cnt_o | ld_cnt_max_o | ld_max_o | ld_min_o | oe_cnt_o | oe_max_o | oe_min_o;
  assign irq_cycle = (|rst_cnt_o) && (|ld_en_o) && !en_o;

  p_onehot_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_pace_o) && $onehot0(ld_en_o) && $onehot0(rst_cnt_o) && $onehot0(act_vec) && $onehot0(ack_o));

  p_irq_highest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cycle |-> ((rst_cnt_o & tc_req_i) != '0) &&
                  (((rst_cnt_o - {{(NUM_CH-1){1'b0}}, 1'b1}) & tc_req_i) == '0));

  p_ack_needs_inta_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> inta_i);

  p_pace_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_vec) |-> ($past(ld_pace_o) == act_vec));

  p_pace_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ld_pace_o) |=> (ld_pace_o == '0));

  p_action_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_vec) |=> (act_vec == '0));

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_o) |-> $past(|(oe_cnt_o | oe_max_o | oe_min_o)));
endmodule

bind mon_ctrl mon_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tc_req_i(tc_req_i), .inta_i(inta_i), .en_o(en_o),
  .rd_data_o(rd_data_o), .ld_pace_o(ld_pace_o), .ld_en_o(ld_en_o), .ld_cnt_o(ld_cnt_o),
  .ld_cnt_max_o(ld_cnt_max_o), .ld_max_o(ld_max_o), .ld_min_o(ld_min_o),
  .rst_cnt_o(rst_cnt_o), .oe_cnt_o(oe_cnt_o), .oe_max_o(oe_max_o), .oe_min_o(oe_min_o),
  .ack_o(ack_o)
);

// File: tb/mon_ctrl_tb.sv
module mon_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 32;
  localparam int DATA_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [10:0]       cmd_word_i = '0;
  logic [NUM_CH-1:0] tc_req_i = '0;
  logic [NUM_CH-1:0] early_i = '0;
  logic              inta_i = 1'b0;
  logic [DATA_W-1:0] rd_bus_i;
  logic              intr_o, en_o;
  logic [DATA_W-1:0] status_o, rd_data_o;
  logic [1:0]        pace_o;
  logic [NUM_CH-1:0] ld_pace_o, ld_en_o, ld_cnt_o, ld_cnt_max_o, ld_max_o, ld_min_o;
  logic [NUM_CH-1:0] rst_cnt_o, oe_cnt_o, oe_max_o, oe_min_o, ack_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // channel read-back model
  always_comb begin
    if (|oe_cnt_o)      rd_bus_i = 16'h1234;
    else if (|oe_max_o) rd_bus_i = 16'hABCD;
    else if (|oe_min_o) rd_bus_i = 16'h0F0F;
    else                rd_bus_i = 16'hDEAD;
  end

  mon_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] kind_now();
    return {|ld_en_o, en_o & (|ld_en_o), |ld_cnt_o, |ld_cnt_max_o, |ld_max_o, |ld_min_o,
            |rst_cnt_o, |oe_cnt_o, |oe_max_o, |oe_min_o};
  endfunction

  function automatic logic [NUM_CH-1:0] all_vec();
    return ld_en_o | ld_cnt_o | ld_cnt_max_o | ld_max_o | ld_min_o | rst_cnt_o |
           oe_cnt_o | oe_max_o | oe_min_o | ack_o | ld_pace_o;
  endfunction

  task automatic run_cmd(string tag, logic [3:0] op, logic [4:0] id, logic [1:0] pace,
                         logic [9:0] exp_kind);
    logic valid_op;
    valid_op = (op <= 4'hB);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_word_i  = {pace, op, id};
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    #1;
    if (valid_op) begin
      chk({tag, " R6 pace strobe"}, ld_pace_o, 32'h1 << id);
      chk({tag, " R6 pace value"}, pace_o, pace);
      chk({tag, " R13 no early action"}, kind_now(), 0);
      @(negedge clk_i); #1;
      chk({tag, " R13 action kind"}, kind_now(), exp_kind);
      chk({tag, " R13 action target"}, all_vec(), 32'h1 << id);
      @(posedge clk_i); #1;
    end else begin
      chk({tag, " R12 no strobe"}, all_vec(), 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 status in reset", status_o, 0);
    chk("R1 rd_data in reset", rd_data_o, 0);
    chk("R1 strobes in reset", all_vec(), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i); #1;
    chk("R1 strobes after reset", all_vec(), 0);
    chk("R1 status after reset", status_o, 0);
    chk("R2 intr idle low", intr_o, 0);
  endtask

  task automatic t_commands();
    run_cmd("R7 start", 4'h0, 5'd9, 2'd2, 10'b1101000000);
    run_cmd("R7 pause", 4'h1, 5'd9, 2'd1, 10'b1000000000);
    run_cmd("R7 resume", 4'h4, 5'd31, 2'd3, 10'b1100000000);
    run_cmd("R9 measure start", 4'h3, 5'd0, 2'd0, 10'b1100001000);
    run_cmd("R9 measure stop", 4'h5, 5'd12, 2'd1, 10'b1000000100);
    chk("R9 stop captures counter", rd_data_o, 16'h1234);
    run_cmd("R10 load counter", 4'h6, 5'd4, 2'd0, 10'b0010000000);
    run_cmd("R10 load max", 4'h7, 5'd5, 2'd0, 10'b0000100000);
    run_cmd("R10 load min", 4'h8, 5'd6, 2'd0, 10'b0000010000);
    chk("R11 loads leave rd_data", rd_data_o, 16'h1234);
    run_cmd("R11 read max", 4'hA, 5'd7, 2'd2, 10'b0000000010);
    chk("R11 read max data", rd_data_o, 16'hABCD);
    run_cmd("R11 read min", 4'hB, 5'd8, 2'd2, 10'b0000000001);
    chk("R11 read min data", rd_data_o, 16'h0F0F);
    run_cmd("R11 read counter", 4'h9, 5'd1, 2'd0, 10'b0000000100);
    chk("R11 read counter data", rd_data_o, 16'h1234);
  endtask

  task automatic t_reserved();
    logic [15:0] st;
    st = status_o;
    run_cmd("R12 code C", 4'hC, 5'd4, 2'd3, 10'b0);
    run_cmd("R12 code F", 4'hF, 5'd2, 2'd1, 10'b0);
    chk("R12 rd_data kept", rd_data_o, 16'h1234);
    chk("R12 status kept", status_o, st);
    run_cmd("R12 next accepted at once", 4'hA, 5'd3, 2'd0, 10'b0000000010);
    chk("R12 follow-up read data", rd_data_o, 16'hABCD);
  endtask

  task automatic t_irq();
    @(negedge clk_i);
    tc_req_i = (32'h1 << 3) | (32'h1 << 7);
    cmd_valid_i = 1'b1;
    cmd_word_i  = {2'd1, 4'h0, 5'd9};
    #1;
    chk("R2 intr follows request", intr_o, 1);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    #1;
    chk("R4 reset strobe lowest", rst_cnt_o, 32'h1 << 3);
    chk("R4 disable strobe", ld_en_o, 32'h1 << 3);
    chk("R4 disable value", en_o, 0);
    chk("R3 no pace for dropped command", ld_pace_o, 0);
    @(negedge clk_i); #1;
    chk("R4 status id", status_o, 16'd3);
    chk("R5 no ack without inta", ack_o, 0);
    cmd_valid_i = 1'b1;
    cmd_word_i  = {2'd0, 4'h9, 5'd2};
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    #1;
    chk("R5 command refused while waiting", all_vec(), 0);
    inta_i = 1'b1;
    #1;
    chk("R5 ack to served channel", ack_o, 32'h1 << 3);
    @(negedge clk_i);
    inta_i   = 1'b0;
    tc_req_i = 32'h1 << 7;
    @(negedge clk_i); #1;
    chk("R4 second request served", rst_cnt_o, 32'h1 << 7);
    @(negedge clk_i); #1;
    chk("R4 second status id", status_o, 16'd7);
    inta_i = 1'b1;
    #1;
    chk("R5 second ack", ack_o, 32'h1 << 7);
    @(negedge clk_i);
    inta_i   = 1'b0;
    tc_req_i = '0;
    #1;
    chk("R2 intr drops", intr_o, 0);
  endtask

  task automatic t_finish();
    early_i = 32'h1 << 5;
    run_cmd("R8 finish early", 4'h2, 5'd5, 2'd0, 10'b1000000000);
    chk("R8 early flag set, id kept", status_o, 16'h0027);
    run_cmd("R8 finish on time", 4'h2, 5'd6, 2'd0, 10'b1000000000);
    chk("R8 early flag clear", status_o, 16'h0007);
    run_cmd("R8 finish early again", 4'h2, 5'd5, 2'd0, 10'b1000000000);
    @(negedge clk_i);
    tc_req_i = 32'h1 << 2;
    @(negedge clk_i); @(negedge clk_i); #1;
    chk("R4 service clears early bit", status_o, 16'd2);
    inta_i = 1'b1;
    @(negedge clk_i);
    inta_i   = 1'b0;
    tc_req_i = '0;
    early_i  = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_commands();
    t_reserved();
    t_irq();
    t_finish();
    run_cmd("R13 command after service", 4'h7, 5'd30, 2'd3, 10'b0000100000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule